// File: doc/BRIEF.md
# Doorbell Interrupt Register File

This block is the small register window of a shared-memory device that links several isolated partitions. Software on the local node sees four 32-bit word registers: an interrupt enable mask, an interrupt status word that clears itself when read, a read-only local identifier, and a write-only doorbell. Writing the doorbell asks for a notification to be sent to one vector of one remote peer. The block checks the request against a small table of peers and of each peer's vector count, and passes on only requests that are in range.

Events arriving for the local node's own vectors are handled in one of two ways. In legacy mode an event loads the status word, and a level interrupt reports any enabled status bit. In message mode an event becomes a one-cycle request on a per-vector line, as long as message interrupts are enabled. In that mode the level interrupt is held low. A separate configuration port loads the number of peers and each peer's vector count.

Top module: `dbell_regfile`

## Requirements
- R1: Offset 0x0 holds the 32-bit interrupt mask and reads back whatever was last written there. Offset 0x8 reads as the `local_id` input, zero-extended. Writes to offset 0x8 change nothing.
- R2: Writes decode only address bits 7:2, so bits 1:0 are ignored. A write to any word other than 0, 1 or 3 has no effect.
- R3: A read returns zero for any address other than exactly 0x0, 0x4 or 0x8. This includes misaligned addresses such as 0x1, the doorbell at 0xC, and 0x10.
- R4: A read of offset 0x4 returns the current status word. From the next cycle the status word is zero.
- R5: In legacy mode with a non-zero `irq_pin_cfg`, `irq_level` is high exactly when (status AND mask) is non-zero. It follows each mask write, status write and status read one cycle later.
- R6: `irq_level` is low whenever `msg_mode` is 1 or `irq_pin_cfg` is zero.
- R7: An accepted doorbell write (word 3) produces `db_valid` high for exactly one cycle, in the cycle after the write. In that cycle `db_dest` = write data bits 31:16 and `db_vector` = write data bits 7:0. Bits 15:8 are ignored.
- R8: A doorbell write is dropped when the destination is not below the configured peer count, or when the vector is not below that peer's configured vector count.
- R9: With `msg_mode`=1, an `evt_in` bit produces the matching `msi_req` bit for one cycle, in the next cycle, but only when `msg_en`=1. The status word is left unchanged.
- R10: With `msg_mode`=0, any `evt_in` bit sets the status word to exactly 1. The old value is replaced, not ORed.
- R11: Reset clears the mask, the status word, the peer count and every vector count. As a result, every doorbell is dropped until the table is loaded again.
- R12: When a legacy event falls in the same cycle as a status read or a status write, the status word becomes 1. A read in that cycle returns the old value.
- R13: A peer count above MAX_PEERS (16) written on the configuration port is stored as MAX_PEERS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| local_id | input | 16 | Identifier of the local node |
| msg_mode | input | 1 | 1 selects per-vector message requests |
| msg_en | input | 1 | Message interrupts enabled |
| irq_pin_cfg | input | 8 | Interrupt pin setting; zero disables the level interrupt |
| evt_in | input | NVEC | Incoming event pulses, one per local vector |
| cfg_npeers_we | input | 1 | Load the peer count |
| cfg_npeers | input | 8 | Peer count value |
| cfg_vcnt_we | input | 1 | Load one peer's vector count |
| cfg_peer_idx | input | 4 | Peer selected for the vector count load |
| cfg_vcnt | input | 8 | Vector count value |
| irq_level | output | 1 | Level interrupt |
| msi_req | output | NVEC | Per-vector message interrupt request pulses |
| db_valid | output | 1 | Accepted doorbell pulse |
| db_dest | output | 16 | Destination peer of the doorbell |
| db_vector | output | 8 | Destination vector of the doorbell |

## Verification
A local event and a software access to the status word can fall in the same clock cycle. The bench provokes this by raising an `evt_in` bit in the very cycle that it reads offset 0x4, and again in a cycle that writes offset 0x4. For the read, the value returned must be the status word from before the event. In both cases the following read must return 1, which shows that the event's value takes priority over both the read-clear and the written data.

// File: rtl/dbell_regfile.sv
`timescale 1ns/1ps
module dbell_regfile #(
  parameter int NVEC      = 4,
  parameter int MAX_PEERS = 16,
  parameter int ID_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [ID_W-1:0] local_id,
  input  logic            msg_mode,
  input  logic            msg_en,
  input  logic [7:0]      irq_pin_cfg,
  input  logic [NVEC-1:0] evt_in,
  input  logic            cfg_npeers_we,
  input  logic [7:0]      cfg_npeers,
  input  logic            cfg_vcnt_we,
  input  logic [3:0]      cfg_peer_idx,
  input  logic [7:0]      cfg_vcnt,
  output logic            irq_level,
  output logic [NVEC-1:0] msi_req,
  output logic            db_valid,
  output logic [15:0]     db_dest,
  output logic [7:0]      db_vector
);
  localparam int PIDX_W = $clog2(MAX_PEERS);
  localparam int CNT_W  = $clog2(MAX_PEERS + 1);

  logic [31:0]      mask_q, stat_q, stat_d;
  logic [CNT_W-1:0] npeers_q;
  logic [7:0]       vcnt_q [MAX_PEERS];

  wire [5:0] word    = bus_addr[7:2];
  wire wr_mask       = bus_wr && (word == 6'd0);
  wire wr_stat       = bus_wr && (word == 6'd1);
  wire wr_db         = bus_wr && (word == 6'd3);
  wire rd_stat       = bus_rd && (bus_addr == 8'h04);
  wire legacy_evt    = !msg_mode && (|evt_in);

  wire [15:0] req_dest = bus_wdata[31:16];
  wire [7:0]  req_vec  = bus_wdata[7:0];
  wire dest_ok = req_dest < 16'(npeers_q);
  wire vec_ok  = req_vec < vcnt_q[req_dest[PIDX_W-1:0]];

  always_comb begin
    stat_d = stat_q;
    if (rd_stat)    stat_d = '0;
    if (wr_stat)    stat_d = bus_wdata;
    if (legacy_evt) stat_d = 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      stat_q    <= '0;
      npeers_q  <= '0;
      msi_req   <= '0;
      db_valid  <= 1'b0;
      db_dest   <= '0;
      db_vector <= '0;
    end else begin
      stat_q  <= stat_d;
      msi_req <= (msg_mode && msg_en) ? evt_in : '0;
      if (wr_mask) mask_q <= bus_wdata;
      if (cfg_npeers_we)
        npeers_q <= (cfg_npeers > 8'(MAX_PEERS)) ? CNT_W'(MAX_PEERS) : cfg_npeers[CNT_W-1:0];
      db_valid <= wr_db && dest_ok && vec_ok;
      if (wr_db) begin
        db_dest   <= req_dest;
        db_vector <= req_vec;
      end
    end
  end

  for (genvar p = 0; p < MAX_PEERS; p++) begin : g_vtab
    always_ff @(posedge clk) begin
      if (!rst_n)                                       vcnt_q[p] <= '0;
      else if (cfg_vcnt_we && cfg_peer_idx == PIDX_W'(p)) vcnt_q[p] <= cfg_vcnt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        8'h00:   bus_rdata = mask_q;
        8'h04:   bus_rdata = stat_q;
        8'h08:   bus_rdata = 32'(local_id);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_level = !msg_mode && (irq_pin_cfg != 8'd0) && (|(stat_q & mask_q));

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(bus_wdata)); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_stat && !legacy_evt) |=> stat_q == 32'd0); // R4
  AST_DB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> $past(bus_wr && bus_addr[7:2] == 6'd3)); // R7
  AST_DB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> (db_dest < MAX_PEERS)); // R8
  AST_MSI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|msi_req) |-> $past(msg_mode && msg_en)); // R9
  AST_LEGACY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_mode && (|evt_in)) |=> stat_q == 32'd1); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_mode || irq_pin_cfg == 8'd0) |-> !irq_level); // R6
endmodule

// File: tb/dbell_regfile_tb.sv
`timescale 1ns/1ps
module dbell_regfile_tb;
  localparam int NVEC = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] local_id = 16'h0007;
  logic msg_mode = 0, msg_en = 0;
  logic [7:0] irq_pin_cfg = 8'd1;
  logic [NVEC-1:0] evt_in = 0;
  logic cfg_npeers_we = 0, cfg_vcnt_we = 0;
  logic [7:0] cfg_npeers = 0, cfg_vcnt = 0;
  logic [3:0] cfg_peer_idx = 0;
  logic irq_level, db_valid;
  logic [NVEC-1:0] msi_req;
  logic [15:0] db_dest;
  logic [7:0] db_vector;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbell_regfile #(.NVEC(NVEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .local_id(local_id), .msg_mode(msg_mode),
    .msg_en(msg_en), .irq_pin_cfg(irq_pin_cfg), .evt_in(evt_in), .cfg_npeers_we(cfg_npeers_we),
    .cfg_npeers(cfg_npeers), .cfg_vcnt_we(cfg_vcnt_we), .cfg_peer_idx(cfg_peer_idx),
    .cfg_vcnt(cfg_vcnt), .irq_level(irq_level), .msi_req(msi_req), .db_valid(db_valid),
    .db_dest(db_dest), .db_vector(db_vector));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse_evt(input logic [NVEC-1:0] e);
    @(negedge clk); evt_in = e;
    @(negedge clk); evt_in = 0;
  endtask

  task automatic set_peers(input logic [7:0] n);
    @(negedge clk); cfg_npeers_we = 1; cfg_npeers = n;
    @(negedge clk); cfg_npeers_we = 0;
  endtask

  task automatic set_vcnt(input logic [3:0] p, input logic [7:0] c);
    @(negedge clk); cfg_vcnt_we = 1; cfg_peer_idx = p; cfg_vcnt = c;
    @(negedge clk); cfg_vcnt_we = 0;
  endtask

  task automatic ring(input logic [7:0] a, input logic [31:0] d, input bit exp_ok, input string tag);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    check(db_valid == exp_ok, tag, 32'(db_valid), 32'(exp_ok));
    if (exp_ok) begin
      check(db_dest == d[31:16], {tag, " dest"}, 32'(db_dest), 32'(d[31:16]));
      check(db_vector == d[7:0], {tag, " vector"}, 32'(db_vector), 32'(d[7:0]));
    end
    @(negedge clk);
    check(db_valid == 1'b0, {tag, " single pulse"}, 32'(db_valid), 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check(v == 0, "R11 mask after reset", v, 0);
    rd(8'h04, v); check(v == 0, "R11 status after reset", v, 0);
    check(irq_level == 0, "R11 irq after reset", 32'(irq_level), 0);
    ring(8'h0C, 32'h0000_0000, 0, "R11 doorbell with empty table");
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_0001); rd(8'h00, v); check(v == 32'hA5A5_0001, "R1 mask readback", v, 32'hA5A5_0001);
    wr(8'h02, 32'h0000_00FF); rd(8'h00, v); check(v == 32'h0000_00FF, "R2 misaligned mask write", v, 32'hFF);
    wr(8'h10, 32'h1234_5678); rd(8'h00, v); check(v == 32'h0000_00FF, "R2 other offset no effect", v, 32'hFF);
    rd(8'h10, v); check(v == 0, "R3 read 0x10", v, 0);
    rd(8'h01, v); check(v == 0, "R3 read 0x1", v, 0);
    rd(8'h0C, v); check(v == 0, "R3 read doorbell", v, 0);
    rd(8'h08, v); check(v == 32'h7, "R1 local id", v, 32'h7);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check(v == 32'h7, "R1 id not writable", v, 32'h7);
  endtask

  task automatic t_status_irq();
    logic [31:0] v;
    wr(8'h04, 32'h3);
    check(irq_level == 1, "R5 irq on enabled status", 32'(irq_level), 1);
    rd(8'h04, v); check(v == 32'h3, "R4 status read value", v, 3);
    check(irq_level == 0, "R5 irq after read clear", 32'(irq_level), 0);
    rd(8'h04, v); check(v == 0, "R4 status cleared", v, 0);
    wr(8'h00, 32'h0); wr(8'h04, 32'h10);
    check(irq_level == 0, "R5 masked status", 32'(irq_level), 0);
    wr(8'h00, 32'h10);
    check(irq_level == 1, "R5 mask write raises irq", 32'(irq_level), 1);
    @(negedge clk); irq_pin_cfg = 0; #1;
    check(irq_level == 0, "R6 pin cfg zero", 32'(irq_level), 0);
    irq_pin_cfg = 1; msg_mode = 1; #1;
    check(irq_level == 0, "R6 message mode", 32'(irq_level), 0);
    msg_mode = 0;
    rd(8'h04, v);
  endtask

  task automatic t_legacy_evt();
    logic [31:0] v;
    wr(8'h04, 32'h6); pulse_evt(4'b0100);
    rd(8'h04, v); check(v == 1, "R10 event replaces status", v, 1);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(8'h04, 32'h8);
    @(negedge clk); bus_rd = 1; bus_addr = 8'h04; evt_in = 4'b0001; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; evt_in = 0;
    check(v == 32'h8, "R12 read returns old value", v, 8);
    rd(8'h04, v); check(v == 1, "R12 event beats read clear", v, 1);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h20; evt_in = 4'b0010;
    @(negedge clk); bus_wr = 0; evt_in = 0;
    rd(8'h04, v); check(v == 1, "R12 event beats status write", v, 1);
  endtask

  task automatic t_msi();
    logic [31:0] v;
    wr(8'h04, 32'h40);
    msg_mode = 1; msg_en = 0;
    @(negedge clk); evt_in = 4'b0010;
    @(negedge clk); evt_in = 0;
    check(msi_req == 0, "R9 disabled no request", 32'(msi_req), 0);
    msg_en = 1;
    @(negedge clk); evt_in = 4'b1000;
    @(negedge clk); evt_in = 0;
    check(msi_req == 4'b1000, "R9 request pulse", 32'(msi_req), 32'h8);
    @(negedge clk);
    check(msi_req == 0, "R9 request one cycle", 32'(msi_req), 0);
    rd(8'h04, v); check(v == 32'h40, "R9 status untouched", v, 32'h40);
    msg_mode = 0; msg_en = 0;
  endtask

  task automatic t_doorbell();
    set_peers(8'd3); set_vcnt(4'd0, 8'd2); set_vcnt(4'd2, 8'd5);
    ring(8'h0C, {16'd2, 8'hAB, 8'd4}, 1, "R7 accepted doorbell");
    ring(8'h0C, {16'd2, 8'h00, 8'd5}, 0, "R8 vector out of range");
    ring(8'h0C, {16'd3, 8'h00, 8'd0}, 0, "R8 peer out of range");
    ring(8'h0C, {16'd1, 8'h00, 8'd0}, 0, "R8 peer with no vectors");
    ring(8'h0D, {16'd0, 8'h00, 8'd1}, 1, "R2 doorbell misaligned");
    set_peers(8'd200); set_vcnt(4'd15, 8'd1);
    ring(8'h0C, {16'd15, 8'h00, 8'd0}, 1, "R13 saturated count peer 15");
    ring(8'h0C, {16'd16, 8'h00, 8'd0}, 0, "R13 peer 16 dropped");
  endtask

  task automatic t_reset_table();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    ring(8'h0C, {16'd0, 8'h00, 8'd0}, 0, "R11 table cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_status_irq();
    t_legacy_evt();
    t_collision();
    t_msi();
    t_doorbell();
    t_reset_table();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule